// File: doc/BRIEF.md
# Memory-Controller Event Counter Bank

The block watches a memory controller and counts what happens there. It has a small bank of counters behind a plain 32-bit register bus. Counter 0 counts clock cycles only and acts as the time base and master switch for the whole bank. Each of the remaining counters picks one event code. A counter with a code counts the pulses on the matching bit of a vector of single-cycle event strobes that the controller drives.

Software programs the event codes and enable bits, then starts the bank through counter 0. It reads the counts back at any time. If the cycle counter wraps, every counter freezes and a level interrupt is raised. Software then reads out the bank and restarts it. A wrap on any other counter is silent: that counter sets its own sticky flag and keeps counting. The two kinds of counter clear in different ways. Counter 0 clears on a low-to-high transition of its clear bit. The other counters clear when a 0 is written to their clear bit, and that bit then reads back as 1.

Top module: `memc_perf_bank`

## Requirements
- R1: After reset all counts read 0, control word 0 reads 0x00000000, control words 1 to 3 read 0x00000002 (clear bit set, everything else 0), and `irq` is low.
- R2: Control word n sits at byte address 4*n and count n at byte address 0x20 + 4*n. A read presents `rdata` with `rvalid` high one cycle after `rd_en`. Any other address reads 0. Writes to count addresses are ignored.
- R3: The control word layout is: bit 0 overflow flag, bit 1 clear, bit 2 enable, bits 31:24 event code. All other bits read 0.
- R4: Counter 0 advances by one on every clock while its enable is 1 and its overflow flag is 0. Its event code field always reads 0.
- R5: Counter n (n = 1..3) advances in a cycle when the bank runs, its own enable is 1, and `evt_vec[code]` is 1. A code at or above `EVT_N` counts nothing.
- R6: While the enable bit of counter 0 is 0, no counter changes except through a clear.
- R7: When counter 0 wraps from all ones to 0, it sets its overflow flag. From then on every counter holds its value, and `irq` goes high.
- R8: When counter n (n = 1..3) wraps, it sets its own overflow flag and keeps counting, and `irq` is unaffected.
- R9: A write to control word 0 clears count 0 and its overflow flag only if the written clear bit is 1 while the stored clear bit is 0. Writing 0 only stores 0.
- R10: A write to control word n (n = 1..3) with clear bit 0 zeroes that count and its overflow flag, and the clear bit then reads back 1.
- R11: `irq` follows the overflow flag of counter 0. Writing 0 to bit 0 of control word 0 (or a clear) drops it. Writing 1 to that bit leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_vec | input | EVT_N | Single-cycle event strobes, bit k matches event code k |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Byte address |
| wdata | input | 32 | Write data |
| rvalid | output | 1 | Read data valid, one cycle after `rd_en` |
| rdata | output | 32 | Read data |
| irq | output | 1 | Level interrupt, set on cycle-counter overflow |

## Verification
A register write or an event strobe seen at a clock edge shows up in the state right after that edge, so `irq` is sampled at the falling edge that follows. A count that is still running at the edge where the write that stops it lands has already counted that edge. Read data arrives one edge after `rd_en`. The driver queues each expected word at the moment it raises `rd_en`, and the monitor compares the data only when `rvalid` is high. Reads of counts are issued only after the bank has been stopped or frozen, so the expected totals follow from the number of edges each stimulus loop spans.

// File: rtl/memc_perf_pkg.sv
`timescale 1ns/1ps
package memc_perf_pkg;
    localparam int BUS_W    = 32;
    localparam int CODE_W   = 8;
    localparam int CODE_LSB = 24;
    localparam int B_OVF    = 0;
    localparam int B_CLR    = 1;
    localparam int B_EN     = 2;
    localparam int CNT_BASE = 32'h20;

    typedef struct packed {
        logic [CODE_W-1:0] code;
        logic              en;
        logic              clr;
        logic              ovf;
    } ctl_t;

    function automatic logic [BUS_W-1:0] ctl_word(input ctl_t c);
        logic [BUS_W-1:0] w;
        w = '0;
        w[CODE_LSB +: CODE_W] = c.code;
        w[B_EN]  = c.en;
        w[B_CLR] = c.clr;
        w[B_OVF] = c.ovf;
        return w;
    endfunction
endpackage

// File: rtl/memc_perf_dec.sv
`timescale 1ns/1ps
module memc_perf_dec #(
    parameter int ADDR_W = 8,
    parameter int N_CTR  = 4,
    localparam int IDX_W = (N_CTR > 1) ? $clog2(N_CTR) : 1
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              ctl_hit,
    output logic              cnt_hit,
    output logic [IDX_W-1:0]  idx
);
    import memc_perf_pkg::*;
    localparam int WORD_W = ADDR_W - 2;
    localparam logic [WORD_W-1:0] CNT_WORD = WORD_W'(CNT_BASE >> 2);
    localparam logic [WORD_W-1:0] N_WORD   = WORD_W'(N_CTR);

    logic [WORD_W-1:0] word;

    always_comb begin
        word    = addr[ADDR_W-1:2];
        ctl_hit = (word < N_WORD);
        cnt_hit = (word >= CNT_WORD) && (word < CNT_WORD + N_WORD);
        idx     = ctl_hit ? IDX_W'(word) : IDX_W'(word - CNT_WORD);
    end
endmodule

// File: rtl/memc_perf_ctr.sv
`timescale 1ns/1ps
module memc_perf_ctr #(
    parameter int CNT_W    = 32,
    parameter int EVT_N    = 64,
    parameter bit IS_CYCLE = 1'b0
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    ctl_wr,
    input  logic [31:0]             wdata,
    input  logic                    run,
    input  logic [EVT_N-1:0]        evt_vec,
    output memc_perf_pkg::ctl_t     ctl_o,
    output logic [CNT_W-1:0]        cnt_o
);
    import memc_perf_pkg::*;
    localparam int SEL_W = (EVT_N > 1) ? $clog2(EVT_N) : 1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        ctl_t             ctl;
    } st_t;

    st_t  st_q, st_d;
    logic hit, bump, at_top, do_clr;

    always_comb begin
        st_d   = st_q;
        do_clr = 1'b0;
        hit    = 1'b0;
        if (IS_CYCLE)
            hit = 1'b1;
        else if (32'(st_q.ctl.code) < EVT_N)
            hit = evt_vec[st_q.ctl.code[SEL_W-1:0]];
        bump   = run && hit && (IS_CYCLE || st_q.ctl.en);
        at_top = &st_q.cnt;
        if (bump) begin
            st_d.cnt = st_q.cnt + 1'b1;
            if (at_top)
                st_d.ctl.ovf = 1'b1;
        end
        if (ctl_wr) begin
            st_d.ctl.en   = wdata[B_EN];
            st_d.ctl.code = IS_CYCLE ? '0 : wdata[CODE_LSB +: CODE_W];
            st_d.ctl.ovf  = (st_q.ctl.ovf && wdata[B_OVF]) || (bump && at_top);
            if (IS_CYCLE) begin
                do_clr        = wdata[B_CLR] && !st_q.ctl.clr;
                st_d.ctl.clr  = wdata[B_CLR];
            end else begin
                do_clr        = !wdata[B_CLR];
                st_d.ctl.clr  = 1'b1;
            end
            if (do_clr) begin
                st_d.cnt     = '0;
                st_d.ctl.ovf = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q          <= '0;
            st_q.ctl.clr  <= !IS_CYCLE;
        end else begin
            st_q <= st_d;
        end
    end

    assign ctl_o = st_q.ctl;
    assign cnt_o = st_q.cnt;

    AST_HALT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !ctl_wr) |=> $stable(st_q.cnt)); // R6

    AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_wr) |=> (st_q.cnt == $past(st_q.cnt) ||
                       st_q.cnt == CNT_W'($past(st_q.cnt) + 1'b1))); // R5

    if (IS_CYCLE) begin : g_cyc_chk
        AST_CYC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
            (run && (&st_q.cnt) && !ctl_wr) |=> (st_q.ctl.ovf && st_q.cnt == '0)); // R7
        AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
            (st_q.ctl.ovf && !ctl_wr) |=> st_q.ctl.ovf); // R11
    end else begin : g_evt_chk
        AST_EVT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
            (ctl_wr && !wdata[B_CLR]) |=> (st_q.cnt == '0 && st_q.ctl.clr)); // R10
    end
endmodule

// File: rtl/memc_perf_bank.sv
`timescale 1ns/1ps
module memc_perf_bank #(
    parameter int N_CTR  = 4,
    parameter int CNT_W  = 32,
    parameter int EVT_N  = 64,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [EVT_N-1:0]  evt_vec,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output logic              rvalid,
    output logic [31:0]       rdata,
    output logic              irq
);
    import memc_perf_pkg::*;
    localparam int IDX_W = (N_CTR > 1) ? $clog2(N_CTR) : 1;

    typedef struct packed {
        logic        vld;
        logic [31:0] data;
    } rd_t;

    logic             ctl_hit, cnt_hit, run;
    logic [IDX_W-1:0] idx;
    ctl_t             ctl_w [N_CTR];
    logic [CNT_W-1:0] cnt_w [N_CTR];
    rd_t              rd_q, rd_d;

    memc_perf_dec #(.ADDR_W(ADDR_W), .N_CTR(N_CTR)) u_dec (
        .addr    (addr),
        .ctl_hit (ctl_hit),
        .cnt_hit (cnt_hit),
        .idx     (idx)
    );

    assign run = ctl_w[0].en && !ctl_w[0].ovf;

    for (genvar g = 0; g < N_CTR; g++) begin : g_ctr
        memc_perf_ctr #(.CNT_W(CNT_W), .EVT_N(EVT_N), .IS_CYCLE(g == 0)) u_ctr (
            .clk     (clk),
            .rst_n   (rst_n),
            .ctl_wr  (wr_en && ctl_hit && (idx == IDX_W'(g))),
            .wdata   (wdata),
            .run     (run),
            .evt_vec (evt_vec),
            .ctl_o   (ctl_w[g]),
            .cnt_o   (cnt_w[g])
        );
    end

    always_comb begin
        rd_d.vld  = rd_en;
        rd_d.data = '0;
        if (rd_en) begin
            if (ctl_hit)
                rd_d.data = ctl_word(ctl_w[idx]);
            else if (cnt_hit)
                rd_d.data = 32'(cnt_w[idx]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    assign rvalid = rd_q.vld;
    assign rdata  = rd_q.data;
    assign irq    = ctl_w[0].ovf;

    AST_RD_LAT: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid |-> $past(rd_en)); // R2

    AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !wr_en) |=> irq); // R11

    AST_FROZEN_EVT: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !wr_en) |=> $stable(cnt_w[N_CTR-1])); // R7
endmodule

// File: tb/sim_memc_perf_bank.sv
`timescale 1ns/1ps
module sim_memc_perf_bank;
    localparam int EVT_N = 64;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [EVT_N-1:0] evt_vec = '0;
    logic             wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0]       addr = '0;
    logic [31:0]      wdata = '0;
    logic             rvalid, irq;
    logic [31:0]      rdata;

    int total = 0;
    int bad   = 0;

    typedef struct {
        logic [31:0] exp;
        string       tag;
    } exp_t;
    exp_t sbq[$];

    always #2 clk = ~clk;

    memc_perf_bank #(.CNT_W(8), .EVT_N(EVT_N)) u0 (
        .clk(clk), .rst_n(rst_n), .evt_vec(evt_vec),
        .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
        .rvalid(rvalid), .rdata(rdata), .irq(irq)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // all driver tasks are entered at a falling edge and return at one
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
        exp_t it;
        it.exp = e; it.tag = tag;
        sbq.push_back(it);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    // monitor: compares read data as it appears
    always @(negedge clk) begin
        if (rst_n && rvalid) begin
            if (sbq.size() == 0) begin
                total++; bad++;
                $display("FAIL R2 unexpected rvalid actual=%h expected=none", rdata);
            end else begin
                exp_t it;
                it = sbq.pop_front();
                chk(rdata, it.exp, it.tag);
            end
        end
    end

    initial begin
        #400000;
        total++; bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk({31'd0, irq}, 32'd0, "R1 irq");
        rd(8'h00, 32'h0, "R1 ctl0");
        rd(8'h04, 32'h2, "R1 ctl1");
        rd(8'h20, 32'h0, "R1 cnt0");
        rd(8'h2C, 32'h0, "R1 cnt3");

        // program event counters: code 4, code 5, code 0x50 (out of range)
        wr(8'h04, 32'h0400_0006);
        wr(8'h08, 32'h0500_0006);
        wr(8'h0C, 32'h5000_0006);
        wr(8'h00, 32'h4);
        for (int i = 0; i < 20; i++) begin
            evt_vec = '0;
            evt_vec[4] = (i % 2 == 0);
            evt_vec[5] = (i % 3 == 0);
            evt_vec[6] = 1'b1;
            @(negedge clk);
        end
        evt_vec = '0;
        wr(8'h00, 32'h0);
        rd(8'h20, 32'd21, "R4 cycle count");
        rd(8'h24, 32'd10, "R5 code 4");
        rd(8'h28, 32'd7, "R5 code 5");
        rd(8'h2C, 32'd0, "R5 code beyond range");
        rd(8'h04, 32'h0400_0006, "R3 ctl1 fields");
        rd(8'h08, 32'h0500_0006, "R3 ctl2 fields");
        rd(8'h00, 32'h0, "R3 ctl0 after stop");

        // R6 halted bank ignores events
        evt_vec[4] = 1'b1;
        repeat (5) @(negedge clk);
        evt_vec = '0;
        rd(8'h24, 32'd10, "R6 halted");

        // R10 clear of an event counter
        wr(8'h04, 32'h0400_0004);
        rd(8'h24, 32'd0, "R10 cleared");
        rd(8'h04, 32'h0400_0006, "R10 clear bit back to 1");
        rd(8'h28, 32'd7, "R10 neighbour kept");

        // R9 cycle counter clear handshake
        wr(8'h00, 32'h6);             // rising clear bit: clears, then runs
        repeat (5) @(negedge clk);
        wr(8'h00, 32'h2);             // held clear bit: no clear
        rd(8'h20, 32'd6, "R9 rising clear then count");
        wr(8'h00, 32'h0);
        rd(8'h20, 32'd6, "R9 writing zero only");
        wr(8'h00, 32'h2);
        rd(8'h20, 32'd0, "R9 zero then one clears");

        // R8 event counter wraps silently
        wr(8'h00, 32'h6);
        evt_vec[4] = 1'b1;
        repeat (10) @(negedge clk);
        evt_vec = '0;
        wr(8'h00, 32'h2);
        wr(8'h00, 32'h0);
        wr(8'h00, 32'h2);
        rd(8'h20, 32'd0, "R9 cycle cleared again");
        wr(8'h00, 32'h6);
        evt_vec[4] = 1'b1;
        repeat (250) @(negedge clk);
        evt_vec = '0;
        wr(8'h00, 32'h2);
        rd(8'h20, 32'd251, "R4 long run");
        rd(8'h24, 32'd4, "R8 wrapped value");
        rd(8'h04, 32'h0400_0007, "R8 own flag set");
        chk({31'd0, irq}, 32'd0, "R8 no irq");

        // R7 cycle counter overflow freezes all
        wr(8'h00, 32'h6);
        evt_vec[4] = 1'b1;
        repeat (10) @(negedge clk);
        evt_vec = '0;
        chk({31'd0, irq}, 32'd1, "R7 irq raised");
        rd(8'h20, 32'd0, "R7 cycle wrapped");
        rd(8'h24, 32'd9, "R7 event counter frozen");
        rd(8'h00, 32'h7, "R7 ctl0 flag");
        repeat (4) @(negedge clk);
        chk({31'd0, irq}, 32'd1, "R11 irq level held");

        // R11 flag write semantics
        wr(8'h00, 32'h7);
        chk({31'd0, irq}, 32'd1, "R11 write one keeps");
        wr(8'h00, 32'h2);
        chk({31'd0, irq}, 32'd0, "R11 write zero drops");
        rd(8'h20, 32'd0, "R11 cycle count kept");

        // R2 read-only counts and unmapped space
        wr(8'h24, 32'hFFFF_FFFF);
        rd(8'h24, 32'd9, "R2 count read-only");
        rd(8'h10, 32'h0, "R2 gap reads zero");
        rd(8'h30, 32'h0, "R2 past counts reads zero");

        // R4 code field of counter 0 stays zero
        wr(8'h00, 32'hAB00_0002);
        rd(8'h00, 32'h2, "R4 ctl0 code ignored");

        repeat (3) @(negedge clk);
        if (sbq.size() != 0) begin
            total++; bad++;
            $display("FAIL R2 missing reads actual=%0d expected=0", sbq.size());
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule